// File: doc/BRIEF.md
# Extended-Precision Result Rounder

This block takes the unrounded output of a floating-point arithmetic unit and turns it into a final 80-bit extended-precision value. The incoming intermediate has more exponent range and more mantissa precision than the output format. The block tests it for underflow and denormalizes it if needed. It then rounds to the selected precision under the selected rounding mode. Last, it checks the rounded magnitude for overflow. Along with the value it reports three exception flags: underflow, overflow and inexact.

The intermediate arrives as a sign, a signed unbiased exponent and a 67-bit mantissa. Bit 66 of the mantissa is the integer bit, so the value is mantissa × 2^(exponent−66). The mantissa is either normalized (bit 66 set) or entirely zero. The precision select can narrow the mantissa to 24 or 53 bits. The result is always packed in the 80-bit layout: sign, 15-bit exponent field with bias 16383, and 64-bit mantissa with an explicit integer bit. The datapath has a single register stage.

Top module: `frnd_unit`

## Requirements
- R1: `out_valid` equals `in_valid` one clock later. All result outputs and flags load together on that edge only when `in_valid` was high, and otherwise hold. A synchronous active-low reset clears every output to zero.
- R2: An all-zero input mantissa produces a zero of the input sign: exponent field 0, mantissa 0, no flags.
- R3: Rounding mode 2'b00 rounds to nearest. A discarded part of exactly one half rounds the kept mantissa to even.
- R4: Rounding mode 2'b01 truncates toward zero. Mode 2'b10 rounds toward minus infinity. Mode 2'b11 rounds toward plus infinity.
- R5: Precision select 2'b01 keeps a 24-bit mantissa with normal exponent range [−126, 127]. Select 2'b10 keeps 53 bits with range [−1022, 1023]. Selects 2'b00 and 2'b11 keep 64 bits with range [−16382, 16383]. Mantissa bits below the kept width are zero. A normal result has field = exponent + 16383 and mantissa bit 63 set.
- R6: When rounding carries out of the kept mantissa, the mantissa becomes 1.000… and the exponent rises by one, before the overflow test.
- R7: An intermediate exponent below the precision's minimum sets UNFL, even when the value is exact. The mantissa is then shifted right to the minimum exponent before rounding. At 64-bit precision the result is an extended denormal: field 0, integer bit clear. At 24 and 53 bits the tiny value is renormalized into the extended layout.
- R8: An underflow too deep for any kept bit to remain returns one of two values, each with the input sign. In modes that round away from zero for that sign, it is the smallest denormal of the precision. Otherwise it is zero.
- R9: A rounded exponent above the precision's maximum sets OVFL. Infinity (field 15'h7FFF, mantissa 0) is returned in mode 00 and in the directed mode that points away from zero for the sign. Otherwise the largest finite value of the precision is returned.
- R10: INEX2 is set when any discarded bit was nonzero, and on every overflow. An exact result leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Intermediate result present this cycle |
| in_sign | input | 1 | Sign of the intermediate |
| in_exp | input | 18 | Signed unbiased exponent of the integer bit |
| in_mant | input | 67 | Mantissa, integer bit at bit 66 |
| in_rmode | input | 2 | Rounding mode select |
| in_prec | input | 2 | Rounding precision select |
| out_valid | output | 1 | Result registered this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Biased exponent field |
| out_mant | output | 64 | Mantissa with explicit integer bit |
| out_unfl | output | 1 | Underflow flag |
| out_ovfl | output | 1 | Overflow flag |
| out_inex | output | 1 | Inexact flag |

## Verification
The bench aims at the half-way tie. A design that ignores the kept LSB there drifts upward by one unit whenever that LSB is even. It probes values just below each precision's minimum exponent. A design that tests tininess after rounding, or loses the sticky bit while shifting, gives a wrong UNFL or a mantissa off by one. Deep underflow in each directed mode catches returning zero where the smallest denormal is due, and the reverse. An all-ones mantissa at the top exponent shows whether the carry is renormalized before the overflow test, and whether infinity or the largest finite value is chosen for the sign.

// File: rtl/frnd_pkg.sv
// Package: shared constants, encodings and the per-precision lane result type
// for the extended-precision rounding unit.
package frnd_pkg;

    localparam int EXT_MANT_W  = 64;      // extended mantissa width
    localparam int EXT_FIELD_W = 15;      // extended exponent field width
    localparam int EXT_BIAS    = 16383;   // extended exponent bias
    localparam int EXT_EMIN    = -16382;  // smallest normal extended exponent
    localparam int WORK_EXP_W  = 20;      // internal signed exponent width
    localparam int NUM_PREC    = 3;       // lanes: 0 extended, 1 single, 2 double

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_DOWN = 2'b10,
        RM_UP   = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        PR_EXT  = 2'b00,
        PR_SGL  = 2'b01,
        PR_DBL  = 2'b10,
        PR_RSVD = 2'b11
    } prec_e;

    // Result of one precision lane before packing into the extended layout.
    typedef struct packed {
        logic                   sign;
        logic [WORK_EXP_W-1:0]  exp;   // signed, unbiased exponent of bit 63
        logic [EXT_MANT_W-1:0]  mant;  // kept bits left-aligned at bit 63
        logic                   unfl;
        logic                   ovfl;
        logic                   inex;
        logic                   inf;
    } lane_res_t;

    // Kept mantissa width of a lane.
    function automatic int lane_bits(input int idx);
        case (idx)
            1:       return 24;
            2:       return 53;
            default: return 64;
        endcase
    endfunction

    // Smallest normal unbiased exponent of a lane.
    function automatic int lane_emin(input int idx);
        case (idx)
            1:       return -126;
            2:       return -1022;
            default: return -16382;
        endcase
    endfunction

    // Largest normal unbiased exponent of a lane.
    function automatic int lane_emax(input int idx);
        case (idx)
            1:       return 127;
            2:       return 1023;
            default: return 16383;
        endcase
    endfunction

endpackage

// File: rtl/frnd_shift.sv
// Module: frnd_shift
// Right shifter with sticky collection, used for denormalization.
// Assumes: amt may exceed W; in that case every bit is shifted out.
module frnd_shift #(
    parameter int W   = 67,
    parameter int SHW = 7
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout,
    output logic           lost
);

    // Shift right and OR together every bit that leaves the word.
    always_comb begin
        if (int'(amt) >= W) begin
            dout = '0;
            lost = |din;
        end else begin
            dout = din >> amt;
            lost = |(din & ~({W{1'b1}} << amt));
        end
    end

endmodule

// File: rtl/frnd_round.sv
// Module: frnd_round
// Rounds a W-bit mantissa to its top P bits under one of four modes.
// Assumes: W - P >= 2 so that a guard bit and a sticky field both exist.
module frnd_round
    import frnd_pkg::*;
#(
    parameter int W = 67,
    parameter int P = 64
) (
    input  logic         sign_i,
    input  logic [1:0]   rmode_i,
    input  logic [W-1:0] v_i,
    output logic [P-1:0] kept_o,
    output logic         carry_o,
    output logic         inex_o
);

    localparam int D = W - P;   // number of discarded bits

    logic [P-1:0] trunc;
    logic         guard;
    logic         sticky;
    logic         bump;
    logic [P:0]   sum;

    assign trunc  = v_i[W-1:D];
    assign guard  = v_i[D-1];
    assign sticky = |v_i[D-2:0];
    assign inex_o = guard | sticky;

    // Decide whether the kept field is incremented.
    always_comb begin
        case (rmode_e'(rmode_i))
            RM_NEAR: bump = guard & (sticky | trunc[0]);
            RM_ZERO: bump = 1'b0;
            RM_DOWN: bump = sign_i & inex_o;
            default: bump = ~sign_i & inex_o;
        endcase
    end

    // Add the increment; the extra top bit is the carry-out.
    assign sum     = {1'b0, trunc} + {{P{1'b0}}, bump};
    assign kept_o  = sum[P-1:0];
    assign carry_o = sum[P];

endmodule

// File: rtl/frnd_lane.sv
// Module: frnd_lane
// One precision lane: underflow test and denormalization, rounding,
// carry renormalization, then overflow test with mode-dependent result.
// Assumes: mant_i is normalized (bit W-1 set); zero inputs are bypassed above.
module frnd_lane
    import frnd_pkg::*;
#(
    parameter int W    = 67,
    parameter int P    = 64,
    parameter int EMIN = -16382,
    parameter int EMAX = 16383
) (
    input  logic                  sign_i,
    input  logic [WORK_EXP_W-1:0] exp_i,
    input  logic [W-1:0]          mant_i,
    input  logic [1:0]            rmode_i,
    output lane_res_t             res_o
);

    localparam int SHW = $clog2(W + 1);
    localparam logic signed [WORK_EXP_W-1:0] EMIN_S = WORK_EXP_W'(EMIN);
    localparam logic signed [WORK_EXP_W-1:0] EMAX_S = WORK_EXP_W'(EMAX);
    localparam logic signed [WORK_EXP_W-1:0] W_S    = WORK_EXP_W'(W);
    localparam logic [SHW-1:0]               SH_MAX = SHW'(W);

    logic signed [WORK_EXP_W-1:0] exp_s;
    logic signed [WORK_EXP_W-1:0] gap;
    logic signed [WORK_EXP_W-1:0] exp_pre;
    logic signed [WORK_EXP_W-1:0] exp_rnd;
    logic                         tiny;
    logic [SHW-1:0]               amt;
    logic [W-1:0]                 shifted;
    logic                         lost;
    logic [W-1:0]                 v;
    logic [P-1:0]                 kept;
    logic [P-1:0]                 mant_rnd;
    logic                         carry;
    logic                         inex_rnd;
    logic                         ovf;
    logic                         away;

    assign exp_s = $signed(exp_i);
    assign tiny  = exp_s < EMIN_S;
    assign gap   = EMIN_S - exp_s;

    // Denormalization distance, clamped to the word width.
    always_comb begin
        if (!tiny)
            amt = '0;
        else if (gap >= W_S)
            amt = SH_MAX;
        else
            amt = gap[SHW-1:0];
    end

    frnd_shift #(.W(W), .SHW(SHW)) u_shift (
        .din  (mant_i),
        .amt  (amt),
        .dout (shifted),
        .lost (lost)
    );

    // Fold the shifted-out bits into the lowest (sticky) position.
    assign v = {shifted[W-1:1], shifted[0] | lost};

    frnd_round #(.W(W), .P(P)) u_round (
        .sign_i  (sign_i),
        .rmode_i (rmode_i),
        .v_i     (v),
        .kept_o  (kept),
        .carry_o (carry),
        .inex_o  (inex_rnd)
    );

    // Renormalize a rounding carry-out and fix the exponent.
    always_comb begin
        exp_pre = tiny ? EMIN_S : exp_s;
        if (carry) begin
            mant_rnd = {1'b1, {(P-1){1'b0}}};
            exp_rnd  = exp_pre + WORK_EXP_W'(1);
        end else begin
            mant_rnd = kept;
            exp_rnd  = exp_pre;
        end
    end

    assign ovf = exp_rnd > EMAX_S;

    // Modes that push the magnitude away from zero for this sign.
    always_comb begin
        case (rmode_e'(rmode_i))
            RM_NEAR: away = 1'b1;
            RM_ZERO: away = 1'b0;
            RM_DOWN: away = sign_i;
            default: away = ~sign_i;
        endcase
    end

    // Assemble the lane result, substituting the overflow value when needed.
    always_comb begin
        res_o.sign = sign_i;
        res_o.unfl = tiny;
        if (ovf) begin
            res_o.ovfl = 1'b1;
            res_o.inex = 1'b1;
            res_o.inf  = away;
            res_o.exp  = EMAX_S;
            res_o.mant = away ? '0 : (64'({P{1'b1}}) << (EXT_MANT_W - P));
        end else begin
            res_o.ovfl = 1'b0;
            res_o.inex = inex_rnd;
            res_o.inf  = 1'b0;
            res_o.exp  = exp_rnd;
            res_o.mant = 64'(mant_rnd) << (EXT_MANT_W - P);
        end
    end

endmodule

// File: rtl/frnd_pack.sv
// Module: frnd_pack
// Packs a lane result into the extended layout. Nonzero values are
// normalized as far as the extended minimum exponent allows; what stays
// unnormalized at that exponent is emitted as an extended denormal.
// Assumes: lane exponent is at least the extended minimum exponent.
module frnd_pack
    import frnd_pkg::*;
(
    input  lane_res_t               res_i,
    output logic [EXT_FIELD_W-1:0]  exp_o,
    output logic [EXT_MANT_W-1:0]   mant_o
);

    logic [6:0]                   lz;
    logic [6:0]                   sh;
    logic signed [WORK_EXP_W-1:0] room;
    logic signed [WORK_EXP_W-1:0] exp_n;
    logic [EXT_MANT_W-1:0]        mant_n;

    // Count leading zeros of the lane mantissa.
    always_comb begin
        lz = 7'd64;
        for (int i = 0; i < EXT_MANT_W; i++)
            if (res_i.mant[i]) lz = 7'(EXT_MANT_W - 1 - i);
    end

    // Limit the left shift to the room above the extended minimum exponent.
    always_comb begin
        room = $signed(res_i.exp) - WORK_EXP_W'(EXT_EMIN);
        if (room > WORK_EXP_W'(63))
            sh = (lz > 7'd63) ? 7'd63 : lz;
        else
            sh = (lz < room[6:0]) ? lz : room[6:0];
        mant_n = res_i.mant << sh;
        exp_n  = $signed(res_i.exp) - WORK_EXP_W'(sh);
    end

    // Encode infinity, zero, denormal or normal.
    always_comb begin
        if (res_i.inf) begin
            exp_o  = {EXT_FIELD_W{1'b1}};
            mant_o = '0;
        end else if (mant_n[EXT_MANT_W-1]) begin
            exp_o  = EXT_FIELD_W'(exp_n + WORK_EXP_W'(EXT_BIAS));
            mant_o = mant_n;
        end else begin
            exp_o  = '0;
            mant_o = mant_n;
        end
    end

endmodule

// File: rtl/frnd_unit.sv
// Module: frnd_unit (top)
// Rounds an unrounded intermediate into an 80-bit extended value with
// UNFL/OVFL/INEX2 flags. One lane per precision is generated; the precision
// select picks one. Results are registered one cycle after in_valid.
// Assumes: in_mant is normalized (top bit set) or all zero.
module frnd_unit
    import frnd_pkg::*;
#(
    parameter int IN_EXP_W = 18,
    parameter int EXTRA_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sign,
    input  logic [IN_EXP_W-1:0]  in_exp,
    input  logic [EXT_MANT_W+EXTRA_W-1:0] in_mant,
    input  logic [1:0]           in_rmode,
    input  logic [1:0]           in_prec,
    output logic                 out_valid,
    output logic                 out_sign,
    output logic [EXT_FIELD_W-1:0] out_exp,
    output logic [EXT_MANT_W-1:0]  out_mant,
    output logic                 out_unfl,
    output logic                 out_ovfl,
    output logic                 out_inex
);

    localparam int IN_MANT_W = EXT_MANT_W + EXTRA_W;
    localparam int SEL_W     = $clog2(NUM_PREC);

    logic [WORK_EXP_W-1:0]   exp_w;
    lane_res_t               lane_res [NUM_PREC];
    lane_res_t               sel_res;
    logic [SEL_W-1:0]        sel;
    logic                    is_zero;
    logic [EXT_FIELD_W-1:0]  pk_exp;
    logic [EXT_MANT_W-1:0]   pk_mant;

    assign exp_w   = {{(WORK_EXP_W-IN_EXP_W){in_exp[IN_EXP_W-1]}}, in_exp};
    assign is_zero = ~|in_mant;

    // One rounding lane per supported precision.
    for (genvar g = 0; g < NUM_PREC; g++) begin : g_lane
        frnd_lane #(
            .W    (IN_MANT_W),
            .P    (lane_bits(g)),
            .EMIN (lane_emin(g)),
            .EMAX (lane_emax(g))
        ) u_lane (
            .sign_i  (in_sign),
            .exp_i   (exp_w),
            .mant_i  (in_mant),
            .rmode_i (in_rmode),
            .res_o   (lane_res[g])
        );
    end

    // Map the precision code to a lane index; the spare code means extended.
    always_comb begin
        case (prec_e'(in_prec))
            PR_SGL:  sel = SEL_W'(1);
            PR_DBL:  sel = SEL_W'(2);
            default: sel = SEL_W'(0);
        endcase
    end

    assign sel_res = lane_res[sel];

    frnd_pack u_pack (
        .res_i  (sel_res),
        .exp_o  (pk_exp),
        .mant_o (pk_mant)
    );

    // Output register: load on in_valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_mant  <= '0;
            out_unfl  <= 1'b0;
            out_ovfl  <= 1'b0;
            out_inex  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign <= in_sign;
                if (is_zero) begin
                    out_exp  <= '0;
                    out_mant <= '0;
                    out_unfl <= 1'b0;
                    out_ovfl <= 1'b0;
                    out_inex <= 1'b0;
                end else begin
                    out_exp  <= pk_exp;
                    out_mant <= pk_mant;
                    out_unfl <= sel_res.unfl;
                    out_ovfl <= sel_res.ovfl;
                    out_inex <= sel_res.inex;
                end
            end
        end
    end

    // R1: valid tracks the input one cycle later.
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1: the result holds while no new input arrives.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_exp) && $stable(out_mant) && $stable(out_inex));
    // R9: the all-ones exponent field only appears as an overflow infinity.
    p_inf_only_ovfl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_exp == {EXT_FIELD_W{1'b1}}) |-> out_ovfl && (out_mant == '0));
    // R10: every overflow is inexact and never an underflow.
    p_ovfl_inex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovfl |-> out_inex && !out_unfl);
    // R7: a nonzero denormal output only comes from an underflow.
    p_denorm_unfl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_exp == '0) && (out_mant != '0) |-> out_unfl);
    // R5: finite nonzero-exponent results carry their integer bit.
    p_norm_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_exp != '0) && (out_exp != {EXT_FIELD_W{1'b1}}) |-> out_mant[EXT_MANT_W-1]);

endmodule

// File: tb/frnd_unit_bench.sv
`timescale 1ns/1ps
module frnd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [17:0] in_exp = '0;
    logic [66:0] in_mant = '0;
    logic [1:0]  in_rmode = '0;
    logic [1:0]  in_prec = '0;
    logic        out_valid, out_sign, out_unfl, out_ovfl, out_inex;
    logic [14:0] out_exp;
    logic [63:0] out_mant;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic        valid;
        logic        sign;
        logic [14:0] exp;
        logic [63:0] mant;
        logic        unfl, ovfl, inex;
        string       tag;
    } rec_t;

    rec_t pend[$];
    rec_t last_res;

    always #2.5 clk = ~clk;   // 200 MHz

    frnd_unit u_frnd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_mant(in_mant), .in_rmode(in_rmode), .in_prec(in_prec),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
        .out_mant(out_mant), .out_unfl(out_unfl), .out_ovfl(out_ovfl), .out_inex(out_inex)
    );

    // Behavioural reference: value = m * 2^(e-66), rounded at the unit in the
    // last place of the chosen precision, computed with wide integers.
    function automatic rec_t model(input logic s, input int e, input logic [66:0] m,
                                   input logic [1:0] rm, input logic [1:0] pr);
        rec_t r;
        int p, emin, emax, base, k, ulp, len, big_e;
        logic [127:0] q, rem, half, one;
        logic inexact, up, away;
        one = 128'd1;
        r.valid = 1'b1; r.sign = s; r.unfl = 0; r.ovfl = 0; r.inex = 0;
        r.exp = '0; r.mant = '0; r.tag = "";
        if (m == '0) return r;
        p    = (pr == 2'b01) ? 24 : (pr == 2'b10) ? 53 : 64;
        emin = (pr == 2'b01) ? -126 : (pr == 2'b10) ? -1022 : -16382;
        emax = (pr == 2'b01) ? 127 : (pr == 2'b10) ? 1023 : 16383;
        r.unfl = (e < emin);
        base = (e < emin) ? emin : e;
        k = base - e + 67 - p;
        if (k > 100) k = 100;
        q    = 128'(m) >> k;
        rem  = 128'(m) - (q << k);
        half = one << (k - 1);
        inexact = (rem != 0);
        case (rm)
            2'b00: up = (rem > half) || (rem == half && q[0]);
            2'b01: up = 1'b0;
            2'b10: up = s && inexact;
            default: up = !s && inexact;
        endcase
        q = q + 128'(up);
        ulp = base - (p - 1);
        if (q == (one << p)) begin q = one << (p - 1); ulp++; end
        len = 0;
        for (int i = 0; i < 128; i++) if (q[i]) len = i + 1;
        big_e = ulp + len - 1;
        r.inex = inexact;
        away = (rm == 2'b00) || (rm == 2'b10 && s) || (rm == 2'b11 && !s);
        if (q != 0 && big_e > emax) begin
            r.ovfl = 1; r.inex = 1;
            if (away) begin r.exp = 15'h7FFF; r.mant = '0; end
            else begin
                r.exp  = 15'(emax + 16383);
                r.mant = 64'(((one << p) - 1) << (64 - p));
            end
        end else if (q == 0) begin
            r.exp = '0; r.mant = '0;
        end else if (big_e < -16382) begin
            r.exp = '0; r.mant = q[63:0];
        end else begin
            r.exp  = 15'(big_e + 16383);
            r.mant = 64'(q << (64 - len));
        end
        return r;
    endfunction

    // Compare the outputs of the previous cycle against the queued expectation.
    task automatic check_out();
        rec_t x;
        if (pend.size() == 0) return;
        x = pend.pop_front();
        checks++;
        if (out_valid !== x.valid || out_sign !== x.sign || out_exp !== x.exp ||
            out_mant !== x.mant || out_unfl !== x.unfl || out_ovfl !== x.ovfl ||
            out_inex !== x.inex) begin
            errors++;
            $display("FAIL %s: got v=%b s=%b e=%h m=%h u=%b o=%b i=%b exp v=%b s=%b e=%h m=%h u=%b o=%b i=%b",
                     x.tag, out_valid, out_sign, out_exp, out_mant, out_unfl, out_ovfl, out_inex,
                     x.valid, x.sign, x.exp, x.mant, x.unfl, x.ovfl, x.inex);
        end
    endtask

    // One clock: check, drive the new inputs, queue what they must produce.
    task automatic step(input logic v, input logic s, input int e, input logic [66:0] m,
                        input logic [1:0] rm, input logic [1:0] pr, input string tag);
        rec_t x;
        @(negedge clk);
        check_out();
        in_valid = v; in_sign = s; in_exp = e[17:0]; in_mant = m;
        in_rmode = rm; in_prec = pr;
        if (v) begin
            x = model(s, e, m, rm, pr);
            last_res = x;
        end else begin
            x = last_res;
            x.valid = 1'b0;
        end
        if (tag != "") x.tag = tag;
        else x.tag = x.ovfl ? "R9 random" : x.unfl ? "R7 random" : "R4 random";
        pend.push_back(x);
    endtask

    function automatic logic [66:0] rnd_mant();
        logic [95:0] w;
        w = {$urandom, $urandom, $urandom};
        return {1'b1, w[65:0]};
    endfunction

    localparam logic [66:0] ONE   = {1'b1, 66'd0};
    localparam logic [66:0] ALL1  = {67{1'b1}};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got run still active, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        last_res = '{valid:0, sign:0, exp:0, mant:0, unfl:0, ovfl:0, inex:0, tag:""};
        // R1: reset clears outputs even with valid input present
        in_valid = 1'b1; in_mant = ALL1;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || out_exp !== 0 || out_mant !== 0 || out_sign !== 0 ||
            out_unfl !== 0 || out_ovfl !== 0 || out_inex !== 0) begin
            errors++;
            $display("FAIL R1 reset: got v=%b e=%h m=%h expected all zero", out_valid, out_exp, out_mant);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        step(1, 1, 5, '0, 2'b00, 2'b00, "R2 signed zero");
        step(1, 0, -900, '0, 2'b11, 2'b01, "R2 zero single");
        step(1, 0, 0, {64'h8000_0000_0000_0001, 3'b100}, 2'b00, 2'b00, "R3 tie odd");
        step(1, 0, 0, {64'h8000_0000_0000_0002, 3'b100}, 2'b00, 2'b00, "R3 tie even");
        step(1, 0, 0, {64'h8000_0000_0000_0002, 3'b101}, 2'b00, 2'b00, "R3 above half");
        step(1, 1, 0, {64'h8000_0000_0000_0002, 3'b011}, 2'b00, 2'b00, "R3 below half");
        for (int rm = 1; rm < 4; rm++) begin
            step(1, 0, 3, {64'hC000_0000_0000_0004, 3'b001}, 2'(rm), 2'b00, "R4 positive");
            step(1, 1, 3, {64'hC000_0000_0000_0004, 3'b001}, 2'(rm), 2'b00, "R4 negative");
        end
        step(1, 0, 10, rnd_mant(), 2'b00, 2'b01, "R5 single");
        step(1, 1, -10, rnd_mant(), 2'b11, 2'b10, "R5 double");
        step(1, 0, 7, rnd_mant(), 2'b00, 2'b11, "R5 spare code extended");
        step(1, 0, 0, ALL1, 2'b00, 2'b00, "R6 carry extended");
        step(1, 0, 3, ALL1, 2'b00, 2'b01, "R6 carry single");
        step(1, 1, 100, ALL1, 2'b10, 2'b10, "R6 carry double");
        step(1, 0, -16390, ONE, 2'b00, 2'b00, "R7 exact ext denormal");
        step(1, 0, -16383, ALL1, 2'b00, 2'b00, "R7 denormal rounds to normal");
        step(1, 1, -130, rnd_mant(), 2'b01, 2'b01, "R7 single tiny");
        step(1, 0, -1040, rnd_mant(), 2'b00, 2'b10, "R7 double tiny");
        for (int rm = 0; rm < 4; rm++) begin
            step(1, 0, -16682, rnd_mant(), 2'(rm), 2'b00, "R8 gross ext pos");
            step(1, 1, -16682, rnd_mant(), 2'(rm), 2'b00, "R8 gross ext neg");
            step(1, 0, -426, rnd_mant(), 2'(rm), 2'b01, "R8 gross single pos");
            step(1, 1, -100000, rnd_mant(), 2'(rm), 2'b10, "R8 gross double neg");
        end
        for (int rm = 0; rm < 4; rm++) begin
            step(1, 0, 16383, ALL1, 2'(rm), 2'b00, "R9 ovf ext pos");
            step(1, 1, 16383, ALL1, 2'(rm), 2'b00, "R9 ovf ext neg");
            step(1, 1, 127, ALL1, 2'(rm), 2'b01, "R9 ovf single");
            step(1, 0, 1024, ONE, 2'(rm), 2'b10, "R9 ovf double exact");
        end
        step(1, 0, 1, ONE, 2'b00, 2'b00, "R10 exact");
        step(1, 1, 1, {1'b1, 65'd0, 1'b1}, 2'b01, 2'b00, "R10 sticky only");
        step(0, 1, 77, ALL1, 2'b11, 2'b01, "R1 idle hold");
        step(0, 0, -5, rnd_mant(), 2'b00, 2'b00, "R1 idle hold");

        for (int n = 0; n < 4000; n++) begin
            logic [1:0] pr;
            int emn, emx, e, pick, pbits;
            logic [66:0] m;
            pr  = 2'($urandom_range(0, 3));
            emn = (pr == 2'b01) ? -126 : (pr == 2'b10) ? -1022 : -16382;
            emx = (pr == 2'b01) ? 127 : (pr == 2'b10) ? 1023 : 16383;
            pbits = (pr == 2'b01) ? 24 : (pr == 2'b10) ? 53 : 64;
            pick = $urandom_range(0, 4);
            case (pick)
                0: e = emn - 75 + $urandom_range(0, 80);
                1: e = emx - 2 + $urandom_range(0, 3);
                2: e = -100000 + $urandom_range(0, 1000);
                default: e = $urandom_range(0, 400) - 200;
            endcase
            m = rnd_mant();
            if ($urandom_range(0, 3) == 0) m = m | (ALL1 >> 1);
            if ($urandom_range(0, 3) == 0)
                m = (m & ~(ALL1 >> pbits)) | (67'd1 << (66 - pbits));
            step(($urandom_range(0, 7) != 0), 1'($urandom), e, m,
                 2'($urandom_range(0, 3)), pr, "");
        end
        step(0, 0, 0, '0, 2'b00, 2'b00, "R1 flush");
        @(negedge clk);
        check_out();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule